// File: doc/BRIEF.md
# Event Timer Register and Counter Interface

This block is the register front end of a multi-channel event timer. It owns the free-running 64-bit main counter, the global control word, a read-only capability word pair, and the per-channel interrupt status bits. It also decodes the 32-bit register address space. Channel comparators and interrupt routing sit outside. They receive a one-hot channel select, a write strobe, the word offset and the write data. Each channel returns its read word on a packed bus, raises status through a set input per channel, and is told to clear its interrupt by a one-cycle pulse.

Software reaches the block through a 32-bit request channel with valid/ready handshakes. A request transfers on a cycle where `req_valid` and `req_ready` are both high. Only reads produce a response. A read response is presented on `rsp_valid`/`rsp_data` in the cycle after acceptance and is held unchanged until `rsp_ready` is high. While a response waits, `req_ready` stays low, so at most one read is ever in flight. The counter advances by one on each cycle where `tick` is high and counting is enabled. It is accessed as two separate 32-bit halves.

Top module: `evt_regif`

## Requirements
- R1: After reset the counter is 0, the control word reads 0, the status reads 0, `glb_en`, `legacy_route`, `arm_pulse`, `disarm_pulse` and `irq_clear` are low, `rsp_valid` is low and `req_ready` is high.
- R2: Offset 0x000 reads the capability word 0x8086A001 with bits 12:8 replaced by the channel count minus one. The count is the parameter clamped to the range 3..32. Offset 0x004 reads the tick period in femtoseconds (parameter `TICK_FS`).
- R3: While control bit 0 (enable) is 1, the counter increases by exactly one on each cycle with `tick` high. It holds when `tick` is low or when enable is 0.
- R4: Offsets 0x0F0 and 0x0F4 read and write the counter's low and high 32-bit halves. A write takes effect only while enable is 0 and is ignored while enable is 1. A carry from the low half propagates into the high half.
- R5: The control word at 0x010 has two writable bits: bit 0 enable and bit 1 legacy route (driven on `legacy_route`). All other bits read 0, and offset 0x014 reads 0 whatever is written to it.
- R6: An enable change from 0 to 1 raises `arm_pulse` for exactly one cycle. An enable change from 1 to 0 raises `disarm_pulse` for exactly one cycle. Rewriting the same enable value raises neither pulse.
- R7: Status at 0x020 bit i is set by `status_set[i]`. A write clears every bit that is written as 1 and is currently set, and pulses `irq_clear[i]` for one cycle for each bit so cleared. A set arriving in the same cycle as the clear wins: the bit stays set and is not pulsed.
- R8: Channel i occupies 0x100 + 0x20*i to 0x11F + 0x20*i. An access there asserts only `ch_sel[i]` with `ch_offset` = address bits 4:0, and a read returns that channel's word from `ch_rdata[32*i +: 32]`. A write pulses `ch_wr`, except at window offset 0x04, which is read-only and never raises `ch_wr`.
- R9: Reads of undefined offsets, of channel windows at or beyond the channel count, or of addresses with bits 1:0 not zero return 0. Writes there change nothing and raise no channel strobe.
- R10: `req_ready` is low while a read response waits. The response data stays stable until accepted with `rsp_ready`. Writes produce no response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Counter advance qualifier |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request can be accepted |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address of the 32-bit word |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read response valid |
| rsp_ready | input | 1 | Read response accepted |
| rsp_data | output | 32 | Read response data |
| count_o | output | 64 | Main counter value |
| glb_en | output | 1 | Global enable |
| legacy_route | output | 1 | Legacy route control bit |
| arm_pulse | output | 1 | One-cycle pulse on enable rise |
| disarm_pulse | output | 1 | One-cycle pulse on enable fall |
| status_set | input | NCH | Per-channel status set |
| irq_clear | output | NCH | Per-channel interrupt clear pulse |
| ch_sel | output | NCH | One-hot channel select on an accepted access |
| ch_wr | output | 1 | Channel write strobe |
| ch_offset | output | 5 | Byte offset inside the channel window |
| ch_wdata | output | 32 | Channel write data |
| ch_rdata | input | 32*NCH | Per-channel read words |

## Verification
The counter is loaded near a 32-bit boundary and then advanced by a known number of tick-qualified cycles. This separates correct increments and carry propagation from holding or dropping ticks, and the same test is repeated with `tick` high but enable low and with counter writes made while running. The status register is driven with several set and clear masks, including a clear that collides with a set, which distinguishes write-one-to-clear from a plain write and shows which side has priority. Channel accesses hit an existing window, the read-only offset, a window past the channel count and a misaligned address, each of which gives a different result from a wrong decode. A stalled response shows whether data is held and new requests are blocked.

// File: rtl/evt_pkg.sv
package evt_pkg;
  localparam int DATA_W = 32;
  localparam int CH_MIN = 3;
  localparam int CH_MAX = 32;
  localparam int CH_BASE = 'h100;
  localparam int CH_WIN_LG = 5;
  localparam int CH_RO_OFS = 'h04;
  localparam int OFS_CAP_LO = 'h000;
  localparam int OFS_CAP_HI = 'h004;
  localparam int OFS_CFG_LO = 'h010;
  localparam int OFS_CFG_HI = 'h014;
  localparam int OFS_STS    = 'h020;
  localparam int OFS_CNT_LO = 'h0F0;
  localparam int OFS_CNT_HI = 'h0F4;
  localparam int CFG_EN_BIT  = 0;
  localparam int CFG_LEG_BIT = 1;
  localparam logic [15:0] VENDOR_WORD = 16'h8086;
  localparam logic [7:0]  REV_WORD    = 8'h01;

  typedef enum logic [3:0] {
    K_NONE, K_CAP_LO, K_CAP_HI, K_CFG_LO, K_CFG_HI,
    K_STS, K_CNT_LO, K_CNT_HI, K_CHAN
  } reg_kind_e;

  function automatic int clamp_ch(input int n);
    if (n < CH_MIN) return CH_MIN;
    if (n > CH_MAX) return CH_MAX;
    return n;
  endfunction
endpackage

// File: rtl/evt_decode.sv
module evt_decode
  import evt_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int NCH = 3,
  localparam int IDX_W = $clog2(NCH)
) (
  input  logic [ADDR_W-1:0] addr,
  output reg_kind_e         kind,
  output logic [IDX_W-1:0]  idx
);
  localparam logic [ADDR_W:0] WIN_LO = (ADDR_W+1)'(CH_BASE);
  localparam logic [ADDR_W:0] WIN_HI = (ADDR_W+1)'(CH_BASE + NCH * (1 << CH_WIN_LG));

  logic in_win;

  assign in_win = ({1'b0, addr} >= WIN_LO) && ({1'b0, addr} < WIN_HI);
  assign idx = IDX_W'((addr - ADDR_W'(CH_BASE)) >> CH_WIN_LG);

  always_comb begin
    kind = K_NONE;
    if (addr[1:0] == 2'b00) begin
      if (in_win) begin
        kind = K_CHAN;
      end else begin
        case (addr)
          ADDR_W'(OFS_CAP_LO): kind = K_CAP_LO;
          ADDR_W'(OFS_CAP_HI): kind = K_CAP_HI;
          ADDR_W'(OFS_CFG_LO): kind = K_CFG_LO;
          ADDR_W'(OFS_CFG_HI): kind = K_CFG_HI;
          ADDR_W'(OFS_STS):    kind = K_STS;
          ADDR_W'(OFS_CNT_LO): kind = K_CNT_LO;
          ADDR_W'(OFS_CNT_HI): kind = K_CNT_HI;
          default:             kind = K_NONE;
        endcase
      end
    end
  end
endmodule

// File: rtl/evt_counter.sv
module evt_counter #(
  parameter int HALF_W = 32,
  localparam int CNT_W = 2 * HALF_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              tick,
  input  logic              ld_lo,
  input  logic              ld_hi,
  input  logic [HALF_W-1:0] ld_data,
  output logic [CNT_W-1:0]  count
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count <= '0;
    end else if (run) begin
      if (tick) count <= count + CNT_W'(1);
    end else begin
      if (ld_lo) count[HALF_W-1:0] <= ld_data;
      if (ld_hi) count[CNT_W-1:HALF_W] <= ld_data;
    end
  end

  // R3
  cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && tick) |=> (count == $past(count) + CNT_W'(1)));
  // R3
  cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((run && !tick) || (!run && !ld_lo && !ld_hi)) |=> $stable(count));
  // R4
  cnt_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && ld_lo) |=> (count[HALF_W-1:0] == $past(ld_data)));
endmodule

// File: rtl/evt_ctrl.sv
module evt_ctrl #(
  parameter int NCH = 3
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cfg_wr,
  input  logic [1:0]     cfg_bits,
  input  logic           sts_wr,
  input  logic [NCH-1:0] sts_bits,
  input  logic [NCH-1:0] status_set,
  output logic           en,
  output logic           leg,
  output logic           arm,
  output logic           disarm,
  output logic [NCH-1:0] status,
  output logic [NCH-1:0] irq_clear
);
  logic           en_nxt;
  logic [NCH-1:0] clr_mask;

  assign en_nxt   = cfg_wr ? cfg_bits[evt_pkg::CFG_EN_BIT] : en;
  assign clr_mask = sts_wr ? (sts_bits & status & ~status_set) : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en        <= 1'b0;
      leg       <= 1'b0;
      arm       <= 1'b0;
      disarm    <= 1'b0;
      status    <= '0;
      irq_clear <= '0;
    end else begin
      en        <= en_nxt;
      if (cfg_wr) leg <= cfg_bits[evt_pkg::CFG_LEG_BIT];
      arm       <= en_nxt & ~en;
      disarm    <= ~en_nxt & en;
      status    <= (status & ~clr_mask) | status_set;
      irq_clear <= clr_mask;
    end
  end

  // R6
  arm_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    arm |-> (en && !$past(en)));
  // R6
  disarm_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    disarm |-> (!en && $past(en)));
  // R7
  clear_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sts_wr |=> ((irq_clear & status) == '0));
  // R7
  set_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((status & ~$past(status) & ~$past(status_set)) == '0));
endmodule

// File: rtl/evt_regif.sv
module evt_regif
  import evt_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int NUM_CH = 3,
  parameter logic [31:0] TICK_FS = 32'd10_000_000,
  localparam int NCH = evt_pkg::clamp_ch(NUM_CH)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  tick,
  input  logic                  req_valid,
  output logic                  req_ready,
  input  logic                  req_write,
  input  logic [ADDR_W-1:0]     req_addr,
  input  logic [DATA_W-1:0]     req_wdata,
  output logic                  rsp_valid,
  input  logic                  rsp_ready,
  output logic [DATA_W-1:0]     rsp_data,
  output logic [2*DATA_W-1:0]   count_o,
  output logic                  glb_en,
  output logic                  legacy_route,
  output logic                  arm_pulse,
  output logic                  disarm_pulse,
  input  logic [NCH-1:0]        status_set,
  output logic [NCH-1:0]        irq_clear,
  output logic [NCH-1:0]        ch_sel,
  output logic                  ch_wr,
  output logic [4:0]            ch_offset,
  output logic [DATA_W-1:0]     ch_wdata,
  input  logic [NCH*DATA_W-1:0] ch_rdata
);
  localparam int IDX_W = $clog2(NCH);
  localparam logic [DATA_W-1:0] CAP_LO =
    {VENDOR_WORD, 1'b1, 1'b0, 1'b1, 5'(NCH - 1), REV_WORD};

  reg_kind_e          kind;
  logic [IDX_W-1:0]   idx;
  logic               acc, wr;
  logic [NCH-1:0]     status;
  logic [DATA_W-1:0]  chan_word, rd_word;

  assign req_ready = ~rsp_valid;
  assign acc = req_valid & req_ready;
  assign wr  = acc & req_write;

  evt_decode #(.ADDR_W(ADDR_W), .NCH(NCH)) u_dec (
    .addr(req_addr), .kind(kind), .idx(idx));

  evt_counter #(.HALF_W(DATA_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .run(glb_en), .tick(tick),
    .ld_lo(wr && kind == K_CNT_LO), .ld_hi(wr && kind == K_CNT_HI),
    .ld_data(req_wdata), .count(count_o));

  evt_ctrl #(.NCH(NCH)) u_ctl (
    .clk(clk), .rst_n(rst_n),
    .cfg_wr(wr && kind == K_CFG_LO), .cfg_bits(req_wdata[1:0]),
    .sts_wr(wr && kind == K_STS), .sts_bits(req_wdata[NCH-1:0]),
    .status_set(status_set), .en(glb_en), .leg(legacy_route),
    .arm(arm_pulse), .disarm(disarm_pulse),
    .status(status), .irq_clear(irq_clear));

  for (genvar i = 0; i < NCH; i++) begin : g_sel
    assign ch_sel[i] = acc && (kind == K_CHAN) && (idx == IDX_W'(i));
  end

  assign ch_wr     = wr && (kind == K_CHAN) && (req_addr[4:0] != 5'(CH_RO_OFS));
  assign ch_offset = req_addr[4:0];
  assign ch_wdata  = req_wdata;

  always_comb begin
    chan_word = '0;
    for (int i = 0; i < NCH; i++) begin
      if (idx == IDX_W'(i)) chan_word = ch_rdata[i*DATA_W +: DATA_W];
    end
  end

  always_comb begin
    case (kind)
      K_CAP_LO: rd_word = CAP_LO;
      K_CAP_HI: rd_word = TICK_FS;
      K_CFG_LO: rd_word = {30'd0, legacy_route, glb_en};
      K_STS:    rd_word = DATA_W'(status);
      K_CNT_LO: rd_word = count_o[DATA_W-1:0];
      K_CNT_HI: rd_word = count_o[2*DATA_W-1:DATA_W];
      K_CHAN:   rd_word = chan_word;
      default:  rd_word = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else if (acc && !req_write) begin
      rsp_valid <= 1'b1;
      rsp_data  <= rd_word;
    end else if (rsp_valid && rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end

  // R8
  sel_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ch_wr |-> $onehot(ch_sel));
  // R8
  ro_offset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ch_wr |-> (ch_offset != 5'(CH_RO_OFS)));
  // R10
  rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data)));
endmodule

// File: tb/evt_regif_bench.sv
module evt_regif_bench;
  localparam int NCH = 3;
  logic clk = 0, rst_n = 0, tick = 1;
  logic req_valid = 0, req_write = 0, rsp_ready = 1;
  logic [11:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic req_ready, rsp_valid, glb_en, legacy_route, arm_pulse, disarm_pulse, ch_wr;
  logic [31:0] rsp_data, ch_wdata;
  logic [63:0] count_o;
  logic [NCH-1:0] status_set = '0, irq_clear, ch_sel;
  logic [4:0] ch_offset;
  logic [NCH*32-1:0] ch_rdata;

  int errors = 0, checks = 0, wr_events = 0;
  logic [31:0] exp_q[$];
  string tag_q[$];
  logic [31:0] cmem [NCH][8];
  logic [31:0] held;

  always #10 clk = ~clk;

  evt_regif u_evt_regif (.*);

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NCH; i++)
        for (int k = 0; k < 8; k++)
          cmem[i][k] <= 32'hC0DE0000 | (i << 8) | k;
    end else if (ch_wr) begin
      wr_events <= wr_events + 1;
      for (int i = 0; i < NCH; i++)
        if (ch_sel[i]) cmem[i][ch_offset[4:2]] <= ch_wdata;
    end
  end

  always_comb
    for (int i = 0; i < NCH; i++) ch_rdata[i*32 +: 32] = cmem[i][ch_offset[4:2]];

  task automatic chk(input logic [63:0] act, input logic [63:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // monitor: pops expected read data as responses are accepted
  always @(negedge clk) begin
    if (rst_n && rsp_valid && rsp_ready) begin
      if (exp_q.size() == 0) begin
        checks++; errors++;
        $display("FAIL R10: unexpected response actual %h expected none", rsp_data);
      end else begin
        chk(rsp_data, exp_q.pop_front(), tag_q.pop_front());
      end
    end
  end

  task automatic bus(input logic w, input logic [11:0] a, input logic [31:0] d,
                     input logic [NCH-1:0] sset);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1; req_write = w; req_addr = a; req_wdata = d; status_set = sset;
    @(negedge clk);
    req_valid = 0; status_set = '0;
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    bus(1, a, d, '0);
  endtask

  task automatic rd(input logic [11:0] a, input logic [31:0] exp, input string tag);
    exp_q.push_back(exp); tag_q.push_back(tag);
    bus(0, a, 32'h0, '0);
  endtask

  task automatic finish_run;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #(20 * 150000);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk({rsp_valid, req_ready, glb_en, legacy_route, arm_pulse, disarm_pulse}, 6'b010000, "R1 outputs");
    chk(irq_clear, 0, "R1 irq_clear");
    rd(12'h010, 0, "R1 control");
    rd(12'h0F0, 0, "R1 counter low");
    rd(12'h0F4, 0, "R1 counter high");
    rd(12'h020, 0, "R1 status");
    // R2 capability
    rd(12'h000, 32'h8086A001 | ((NCH - 1) << 8), "R2 capability low");
    rd(12'h004, 32'd10_000_000, "R2 tick period");
    // R4 load while disabled
    wr(12'h0F0, 32'hFFFFFFFE);
    wr(12'h0F4, 32'h12);
    rd(12'h0F0, 32'hFFFFFFFE, "R4 low load");
    rd(12'h0F4, 32'h12, "R4 high load");
    // R6 enable rise, R3 hold with tick low
    tick = 0;
    wr(12'h010, 32'h1);
    chk(arm_pulse, 1, "R6 arm pulse");
    @(negedge clk);
    chk(arm_pulse, 0, "R6 arm single cycle");
    rd(12'h0F0, 32'hFFFFFFFE, "R3 hold tick low");
    // R3 three ticks with carry (R4)
    @(negedge clk); tick = 1;
    repeat (3) @(negedge clk);
    tick = 0;
    rd(12'h0F0, 32'h1, "R3 count low after 3 ticks");
    rd(12'h0F4, 32'h13, "R4 carry into high");
    // R4 write ignored while running
    wr(12'h0F0, 32'h55);
    rd(12'h0F0, 32'h1, "R4 write ignored while enabled");
    // R5 write mask
    wr(12'h010, 32'hFFFFFFFF);
    chk(arm_pulse, 0, "R6 no pulse on same enable");
    chk(legacy_route, 1, "R5 legacy output");
    rd(12'h010, 32'h3, "R5 control mask");
    wr(12'h014, 32'hFFFFFFFF);
    rd(12'h014, 0, "R5 upper control");
    // R6 disable
    wr(12'h010, 32'h0);
    chk(disarm_pulse, 1, "R6 disarm pulse");
    @(negedge clk);
    chk(disarm_pulse, 0, "R6 disarm single cycle");
    tick = 1;
    repeat (5) @(negedge clk);
    tick = 0;
    rd(12'h0F0, 32'h1, "R3 hold while disabled");
    // R7 status
    @(negedge clk); status_set = 3'b101;
    @(negedge clk); status_set = '0;
    rd(12'h020, 32'h5, "R7 status set");
    wr(12'h020, 32'h6);
    chk(irq_clear, 3'b100, "R7 clear pulse");
    rd(12'h020, 32'h1, "R7 status after clear");
    bus(1, 12'h020, 32'h1, 3'b001);
    chk(irq_clear, 3'b000, "R7 set wins no pulse");
    rd(12'h020, 32'h1, "R7 set wins");
    // R8 channel decode
    wr(12'h128, 32'hA5A5);
    chk(wr_events, 1, "R8 write strobe");
    rd(12'h128, 32'hA5A5, "R8 channel 1 readback");
    rd(12'h150, 32'hC0DE0204, "R8 channel 2 read");
    wr(12'h104, 32'hDEAD);
    chk(wr_events, 1, "R8 read-only offset no strobe");
    rd(12'h104, 32'hC0DE0001, "R8 read-only offset kept");
    // R9 undefined
    wr(12'h160, 32'h77);
    chk(wr_events, 1, "R9 absent channel no strobe");
    rd(12'h160, 0, "R9 absent channel read");
    rd(12'h0F8, 0, "R9 undefined offset");
    rd(12'h002, 0, "R9 misaligned read");
    wr(12'h012, 32'h1);
    chk(glb_en, 0, "R9 misaligned write ignored");
    // R10 stall
    rsp_ready = 0;
    rd(12'h004, 32'd10_000_000, "R10 stalled data");
    held = rsp_data;
    repeat (3) @(negedge clk);
    chk({rsp_valid, req_ready}, 2'b10, "R10 stall handshake");
    chk(rsp_data, held, "R10 data stable");
    @(posedge clk); #2 rsp_ready = 1;
    repeat (3) @(negedge clk);
    chk(exp_q.size(), 0, "R10 all responses seen");
    finish_run();
  end
endmodule